// File: doc/BRIEF.md
# Interrupt Distributor Register Front End

This block is the register port of a simplified interrupt distributor. The distributor handles one security state and one interrupt group. A host reads and writes 32-bit words over a plain synchronous register port. The block keeps three state arrays for the shared interrupts: enable, pending and active. It also keeps one global group-enable flag. All of this state drives output pins, so neighbouring logic can act on it.

Each state array appears at two word ranges. A write to the set range turns bits on. A write to the clear range turns bits off. Both ranges read back the same stored bits. Word 0 of each array belongs to the private interrupt IDs 0 to 31, which this block does not hold. That word reads as zero and ignores writes. The group range reads as all ones, because every interrupt is in the single group. Every other address in the map reads as zero and ignores writes. Read data is registered, so the host sees it in the cycle after it presents the address.

The word-address map is fixed. Offsets below are given as byte offsets, and the port carries the byte offset shifted right by two.

Top module: `irqd_regfront`

## Requirements
- R1: After reset, the enable, pending and active arrays are all zero and `grp_en_o` is 0. A read of the control word (byte 0x000) returns 0x00000050.
- R2: In the control word, bit 0 is the group enable. It stores the written value and drives `grp_en_o` from the next cycle on. Bit 4 (affinity routing) and bit 6 (security disabled) always read 1. All other bits read 0, and writes to them have no effect.
- R3: The type word (byte 0x004) reads as follows:
  - bits [4:0] = min(32+NUM_SHARED, 1024)/32 − 1;
  - bits [7:5] = 0;
  - bit 16 = 0 (no message interrupts) and bit 17 = 0 (no locality-specific interrupts);
  - bits [23:19] = 9 (ten ID bits).
  
  With the default of 64 shared interrupts it reads 0x00480002. Writes are ignored.
- R4: The implementer word (byte 0x008) reads {PRODUCT_CODE in [31:24], 12'h0, VENDOR_CODE in [11:0]}, which is 0x4B00043B by default. Writes are ignored.
- R5: The set ranges are enable at 0x100, pending at 0x200 and active at 0x300. Word n of a set range covers shared interrupt IDs 32n to 32n+31. A 1 in the written data sets the matching bit, and a 0 leaves it unchanged.
- R6: The clear ranges are enable at 0x180, pending at 0x280 and active at 0x380. A 1 in the written data clears the matching bit, and a 0 leaves it unchanged.
- R7: A read of word n at either the set range or the clear range of an array returns the current 32 state bits for that word.
- R8: In all six ranges, word 0 (the private IDs) and every word n > NUM_SHARED/32 read zero and leave all state unchanged when written.
- R9: The group range (bytes 0x080–0x0FC) reads 0xFFFFFFFF and ignores writes.
- R10: Every other address reads zero and ignores writes. This includes the legacy target range 0x800, the modifier and access ranges 0xD00/0xE00, and the SGI pending range 0xF10–0xF2C.
- R11: `reg_rdata` shows, one cycle later, the value of the word addressed in the current cycle. When a write happens in the same cycle, the read returns the value from before the write.
- R12: The three arrays are independent. Bit i of `irq_enable_o`, `irq_pending_o` and `irq_active_o` belongs to interrupt ID 32+i. A cycle with no write leaves all of them unchanged.
- R13: The identification word (byte 0xFFE8) reads 0x00000030, which is architecture revision 3 in bits [7:4]. Writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_waddr | input | 14 | Word address (byte offset >> 2) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| grp_en_o | output | 1 | Global group enable |
| irq_enable_o | output | NUM_SHARED | Shared interrupt enable bits |
| irq_pending_o | output | NUM_SHARED | Shared interrupt pending bits |
| irq_active_o | output | NUM_SHARED | Shared interrupt active bits |

## Verification
The assertions assume three things about the host:
- it holds reset for at least one clock;
- every address and data input has a known value at each clock edge;
- it treats a read as a free side effect of every cycle, whether or not it writes.

The stimulus drives inputs only at falling edges and keeps them at defined values throughout. It mixes directed accesses to each range boundary with random word-aligned traffic. That traffic draws only from the decoded ranges and a few addresses that should read zero, so every assertion antecedent gets covered.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int unsigned WADDR_W   = 14;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned WORD_IX_W = 5;
    localparam int unsigned NUM_KINDS = 3;

    localparam int unsigned CTRL_GRP_BIT   = 0;
    localparam int unsigned CTRL_ROUTE_BIT = 4;
    localparam int unsigned CTRL_NOSEC_BIT = 6;

    localparam logic [WADDR_W-1:0] WA_CTRL  = 14'h0000;
    localparam logic [WADDR_W-1:0] WA_TYPE  = 14'h0001;
    localparam logic [WADDR_W-1:0] WA_IIDR  = 14'h0002;
    localparam logic [WADDR_W-1:0] WA_IDENT = 14'h3FFA;

    localparam logic [DATA_W-1:0] IDENT_WORD = 32'h0000_0030;
    localparam int unsigned ID_BITS = 10;

    typedef enum logic [2:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_IIDR, RG_IDENT, RG_GROUP, RG_ARRAY
    } region_e;

    typedef struct packed {
        region_e               region;
        logic [1:0]            kind;   // 1 enable, 2 pending, 3 active
        logic                  clr;
        logic [WORD_IX_W-1:0]  word;
    } dec_t;

    function automatic logic [DATA_W-1:0] type_word(int unsigned num_shared);
        int unsigned total;
        logic [DATA_W-1:0] v;
        total = 32 + num_shared;
        if (total > 1024) total = 1024;
        v = '0;
        v[4:0]   = 5'((total / 32) - 1);
        v[23:19] = 5'(ID_BITS - 1);
        return v;
    endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
    import irqd_pkg::*;
(
    input  logic [WADDR_W-1:0] waddr,
    output dec_t               dec
);
    always_comb begin
        dec        = '0;
        dec.region = RG_NONE;
        dec.kind   = waddr[7:6];
        dec.clr    = waddr[5];
        dec.word   = waddr[4:0];
        if (waddr == WA_CTRL)                          dec.region = RG_CTRL;
        else if (waddr == WA_TYPE)                     dec.region = RG_TYPE;
        else if (waddr == WA_IIDR)                     dec.region = RG_IIDR;
        else if (waddr == WA_IDENT)                    dec.region = RG_IDENT;
        else if (waddr[13:5] == 9'd1)                  dec.region = RG_GROUP;
        else if (waddr[13:8] == 6'd0 && waddr[7:6] != 2'd0)
                                                       dec.region = RG_ARRAY;
    end
endmodule

// File: rtl/irqd_state_bank.sv
module irqd_state_bank
    import irqd_pkg::*;
#(
    parameter int unsigned NUM_SHARED = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_set,
    input  logic                  wr_clr,
    input  logic [WORD_IX_W-1:0]  word,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_SHARED-1:0] state,
    output logic [DATA_W-1:0]     rd_word
);
    localparam int unsigned NWORDS = NUM_SHARED / 32;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [WORD_IX_W-1:0] MY_IX = WORD_IX_W'(w + 1);
        always_ff @(posedge clk) begin
            if (rst)
                state[w*32 +: 32] <= '0;
            else if (wr_set && word == MY_IX)
                state[w*32 +: 32] <= state[w*32 +: 32] | wdata;
            else if (wr_clr && word == MY_IX)
                state[w*32 +: 32] <= state[w*32 +: 32] & ~wdata;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NWORDS; w++)
            if (word == WORD_IX_W'(w + 1)) rd_word = state[w*32 +: 32];
    end
endmodule

// File: rtl/irqd_regfront.sv
module irqd_regfront
    import irqd_pkg::*;
#(
    parameter int unsigned NUM_SHARED   = 64,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] VENDOR_CODE  = 12'h43B
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [13:0]           reg_waddr,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  grp_en_o,
    output logic [NUM_SHARED-1:0] irq_enable_o,
    output logic [NUM_SHARED-1:0] irq_pending_o,
    output logic [NUM_SHARED-1:0] irq_active_o
);
    localparam logic [DATA_W-1:0] TYPE_VAL = type_word(NUM_SHARED);
    localparam logic [DATA_W-1:0] IIDR_VAL = {PRODUCT_CODE, 12'h000, VENDOR_CODE};

    dec_t                  dec;
    logic                  grp_en_q;
    logic [NUM_SHARED-1:0] bank_state [NUM_KINDS];
    logic [DATA_W-1:0]     bank_rd    [NUM_KINDS];
    logic [DATA_W-1:0]     rd_next;

    irqd_decode u_dec (.waddr(reg_waddr), .dec(dec));

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
        logic hit;
        assign hit = (dec.region == RG_ARRAY) && (dec.kind == 2'(k + 1));
        irqd_state_bank #(.NUM_SHARED(NUM_SHARED)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_set (reg_wr && hit && !dec.clr),
            .wr_clr (reg_wr && hit &&  dec.clr),
            .word   (dec.word),
            .wdata  (reg_wdata),
            .state  (bank_state[k]),
            .rd_word(bank_rd[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            grp_en_q <= 1'b0;
        else if (reg_wr && dec.region == RG_CTRL)
            grp_en_q <= reg_wdata[CTRL_GRP_BIT];
    end

    always_comb begin
        rd_next = '0;
        unique case (dec.region)
            RG_CTRL: begin
                rd_next[CTRL_GRP_BIT]   = grp_en_q;
                rd_next[CTRL_ROUTE_BIT] = 1'b1;
                rd_next[CTRL_NOSEC_BIT] = 1'b1;
            end
            RG_TYPE:  rd_next = TYPE_VAL;
            RG_IIDR:  rd_next = IIDR_VAL;
            RG_IDENT: rd_next = IDENT_WORD;
            RG_GROUP: rd_next = '1;
            RG_ARRAY: rd_next = bank_rd[dec.kind - 2'd1];
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else     reg_rdata <= rd_next;
    end

    assign grp_en_o      = grp_en_q;
    assign irq_enable_o  = bank_state[0];
    assign irq_pending_o = bank_state[1];
    assign irq_active_o  = bank_state[2];
endmodule

// File: rtl/irqd_regfront_chk.sv
module irqd_regfront_chk #(
    parameter int unsigned NUM_SHARED = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic [13:0]           reg_waddr,
    input logic                  reg_wr,
    input logic [31:0]           reg_wdata,
    input logic [31:0]           reg_rdata,
    input logic                  grp_en_o,
    input logic [NUM_SHARED-1:0] irq_enable_o,
    input logic [NUM_SHARED-1:0] irq_pending_o,
    input logic [NUM_SHARED-1:0] irq_active_o
);
    localparam int unsigned TOTAL = (32 + NUM_SHARED > 1024) ? 1024 : 32 + NUM_SHARED;
    localparam logic [4:0]  LINES = 5'(TOTAL / 32 - 1);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_enable_o == '0 && irq_pending_o == '0 &&
                        irq_active_o == '0 && !grp_en_o));

    p_ctrl_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_waddr) == 14'h0) |->
            (reg_rdata[6:4] == 3'b101 && reg_rdata[31:7] == '0 && reg_rdata[3:1] == '0));

    p_grp_store_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr) && $past(reg_waddr) == 14'h0) |->
            (grp_en_o == $past(reg_wdata[0])));

    p_type_fields_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_waddr) == 14'h1) |->
            (reg_rdata[4:0] == LINES && reg_rdata[7:5] == 3'b0 &&
             reg_rdata[17:16] == 2'b0 && reg_rdata[23:19] == 5'd9));

    p_private_raz_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_waddr[13:8]) == 6'd0 &&
         $past(reg_waddr[7:6]) != 2'd0 && $past(reg_waddr[4:0]) == 5'd0) |->
            (reg_rdata == '0));

    p_group_ones_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_waddr[13:5]) == 9'd1) |-> (reg_rdata == '1));

    p_quiet_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_wr)) |->
            ($stable(irq_enable_o) && $stable(irq_pending_o) &&
             $stable(irq_active_o) && $stable(grp_en_o)));
endmodule

bind irqd_regfront irqd_regfront_chk #(.NUM_SHARED(NUM_SHARED)) u_chk (
    .clk(clk), .rst(rst), .reg_waddr(reg_waddr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_en_o(grp_en_o),
    .irq_enable_o(irq_enable_o), .irq_pending_o(irq_pending_o),
    .irq_active_o(irq_active_o)
);

// File: tb/irqd_regfront_tb_top.sv
module irqd_regfront_tb_top;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [13:0]   reg_waddr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          grp_en_o;
    logic [NS-1:0] irq_enable_o, irq_pending_o, irq_active_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [NS-1:0] m_arr [3];
    logic          m_grp;
    logic [31:0]   exp_rd;

    always #2 clk = ~clk;   // 250 MHz

    irqd_regfront #(.NUM_SHARED(NS)) dut_i (
        .clk(clk), .rst(rst), .reg_waddr(reg_waddr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_en_o(grp_en_o),
        .irq_enable_o(irq_enable_o), .irq_pending_o(irq_pending_o),
        .irq_active_o(irq_active_o)
    );

    function automatic logic [31:0] model_read(input int b);
        int kind, word;
        logic [31:0] v;
        int total;
        if (b == 0) return 32'h50 | {31'b0, m_grp};
        if (b == 4) begin
            total = (32 + NS > 1024) ? 1024 : 32 + NS;
            return 32'(total / 32 - 1) | (32'd9 << 19);
        end
        if (b == 8)       return 32'h4B00043B;
        if (b == 'hFFE8)  return 32'h30;
        if (b >= 'h80 && b < 'h100) return 32'hFFFFFFFF;
        if (b >= 'h100 && b < 'h400) begin
            kind = (b - 'h100) / 'h100;
            word = (b % 'h80) / 4;
            if (word < 1 || word > NS / 32) return 32'h0;
            for (int i = 0; i < 32; i++) v[i] = m_arr[kind][(word - 1) * 32 + i];
            return v;
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        int b, kind, word;
        if (rst) begin
            for (int k = 0; k < 3; k++) m_arr[k] = '0;
            m_grp  = 1'b0;
            exp_rd = '0;
        end else begin
            b = int'(reg_waddr) * 4;
            exp_rd = model_read(b);
            if (reg_wr) begin
                if (b == 0) m_grp = reg_wdata[0];
                if (b >= 'h100 && b < 'h400) begin
                    kind = (b - 'h100) / 'h100;
                    word = (b % 'h80) / 4;
                    if (word >= 1 && word <= NS / 32)
                        for (int i = 0; i < 32; i++)
                            if (reg_wdata[i])
                                m_arr[kind][(word - 1) * 32 + i] = ((b % 'h100) < 'h80);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!rst) begin
            checks++;
            if (reg_rdata !== exp_rd || grp_en_o !== m_grp || irq_enable_o !== m_arr[0] ||
                irq_pending_o !== m_arr[1] || irq_active_o !== m_arr[2]) begin
                errors++;
                $display("FAIL R11 model: rdata %h exp %h grp %b exp %b en %h exp %h pd %h exp %h ac %h exp %h",
                         reg_rdata, exp_rd, grp_en_o, m_grp, irq_enable_o, m_arr[0],
                         irq_pending_o, m_arr[1], irq_active_o, m_arr[2]);
            end
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int b, input logic [31:0] d);
        reg_waddr = 14'(b / 4); reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int b, input logic [31:0] exp, input string tag);
        reg_waddr = 14'(b / 4); reg_wr = 1'b0;
        tick();
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd('h000, 32'h50, "R1 ctrl after reset");
        chk("R1 state after reset", {63'b0, grp_en_o} | 64'(irq_enable_o | irq_pending_o | irq_active_o), 64'h0);
        // R2 control
        wr('h000, 32'hFFFFFFFF);
        chk("R2 grp_en set", 64'(grp_en_o), 64'h1);
        rd('h000, 32'h51, "R2 ctrl readback");
        wr('h000, 32'h0);
        rd('h000, 32'h50, "R2 ctrl fixed bits");
        chk("R2 grp_en clear", 64'(grp_en_o), 64'h0);
        // R3 / R4 / R13 constant words
        rd('h004, 32'h00480002, "R3 type word");
        wr('h004, 32'hFFFFFFFF);
        rd('h004, 32'h00480002, "R3 type write ignored");
        rd('h008, 32'h4B00043B, "R4 implementer word");
        wr('h008, 32'h0);
        rd('h008, 32'h4B00043B, "R4 write ignored");
        rd('hFFE8, 32'h30, "R13 ident word");
        wr('hFFE8, 32'h0);
        rd('hFFE8, 32'h30, "R13 write ignored");
        // R5 set
        wr('h104, 32'h000000F0);
        rd('h104, 32'h000000F0, "R5 set enable");
        wr('h104, 32'h0000000F);
        rd('h104, 32'h000000FF, "R5 zero bits unchanged");
        chk("R12 enable pins", 64'(irq_enable_o), 64'hFF);
        // R6 clear, R7 alias
        wr('h184, 32'h00000011);
        rd('h104, 32'h000000EE, "R6 clear enable");
        rd('h184, 32'h000000EE, "R7 clear range reads state");
        // R12 independence
        wr('h208, 32'h80000000);
        chk("R12 pending bit 63", 64'(irq_pending_o), 64'h8000000000000000);
        chk("R12 enable untouched", 64'(irq_enable_o), 64'hEE);
        rd('h288, 32'h80000000, "R7 pending via clear range");
        wr('h304, 32'h5);
        wr('h384, 32'h1);
        rd('h304, 32'h4, "R6 clear active");
        chk("R12 active pins", 64'(irq_active_o), 64'h4);
        // R8 private and out-of-range words
        wr('h100, 32'hFFFFFFFF);
        wr('h280, 32'hFFFFFFFF);
        rd('h100, 32'h0, "R8 private word raz");
        rd('h180, 32'h0, "R8 private clear raz");
        wr('h10C, 32'hFFFFFFFF);
        rd('h10C, 32'h0, "R8 word past shared raz");
        chk("R8 state untouched", 64'(irq_enable_o ^ irq_pending_o),
            64'h80000000000000EE);
        // R9 group
        rd('h080, 32'hFFFFFFFF, "R9 group first");
        wr('h0FC, 32'h0);
        rd('h0FC, 32'hFFFFFFFF, "R9 group write ignored");
        // R10 other space
        wr('h800, 32'hFFFFFFFF);
        rd('h800, 32'h0, "R10 target range");
        wr('hD00, 32'hFFFFFFFF);
        rd('hD00, 32'h0, "R10 modifier range");
        rd('hE00, 32'h0, "R10 access range");
        wr('hF20, 32'hFFFFFFFF);
        rd('hF20, 32'h0, "R10 sgi pending range");
        chk("R10 state untouched", 64'(irq_enable_o), 64'hEE);
        // R11 read during write returns old value
        reg_waddr = 14'('h104 / 4); reg_wr = 1'b1; reg_wdata = 32'hFFFFFFFF;
        tick();
        reg_wr = 1'b0;
        chk("R11 read old value during write", 64'(reg_rdata), 64'hEE);
        rd('h104, 32'hFFFFFFFF, "R11 new value next read");
        // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: reg_waddr = 14'h0;
                1: reg_waddr = 14'($urandom_range(0, 2));
                2: reg_waddr = 14'h3FFA;
                3: reg_waddr = 14'($urandom_range('h20, 'h3F));
                4: reg_waddr = 14'($urandom_range('h200, 'h3FF));
                default: reg_waddr = 14'($urandom_range('h40, 'hFF));
            endcase
            reg_wr    = $urandom_range(0, 1) == 1;
            reg_wdata = $urandom;
            tick();
        end
        reg_wr = 1'b0;
        tick();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule